// File: doc/BRIEF.md
# UART FIFO-Level Interrupt Controller

This block builds the interrupt outputs for a UART that has a receive FIFO and a transmit FIFO. It receives the fill counts of both FIFOs and compares each against a threshold picked by a 3-bit code. The threshold is a number of eighths of the FIFO depth. The receive side asks "at least this full" and the transmit side asks "at most this full". It also receives one-cycle pulses for receive timeout, framing error, parity error, break error and overrun error.

Each of the seven sources latches into a raw status bit. A read-back mask register gates the raw bits into masked status bits and into per-source interrupt lines. The combined interrupt is the OR of all masked bits.

Software reaches the block through a simple port: a synchronous write and a combinational read, both addressed by word index. The UART shifters, baud generation and the FIFOs are outside the block.

Top module: `uart_irq_ctrl`

## Requirements
- R1: In reset, the level register (address 0) reads 0x12, meaning code 2 in both fields. The mask register (address 1) and the raw status (address 2) read 0.
- R2: The receive code sits in bits 5:3 of address 0. It selects a threshold of k·DEPTH/8, where k is 1, 2, 4, 6 or 7 for codes 0 to 4. Raw bit 4 sets one clock after the receive count changes from below that threshold to at or above it.
- R3: The transmit code sits in bits 2:0 of address 0 and uses the same k table. Raw bit 5 sets one clock after the transmit count changes from above that threshold to at or below it. Because the comparison history resets to "not met", an empty transmit FIFO sets bit 5 one clock after reset is released.
- R4: Codes 5, 6 and 7 act as code 4, the 7/8 threshold. Address 0 reads back the code exactly as written.
- R5: A level source sets its raw bit only on the change from "not met" to "met". If a raw bit is cleared while the condition still holds, the bit stays clear.
- R6: A pulse on the timeout, framing, parity, break or overrun input sets raw bit 6, 7, 8, 9 or 10 respectively, one clock later.
- R7: Writing to address 4 clears every raw bit written as 1. If a set and a clear hit the same bit in the same clock, the set wins.
- R8: Address 1 holds the mask. Bit 4 is receive, bit 5 transmit, bit 6 timeout, bit 7 framing, bit 8 parity, bit 9 break and bit 10 overrun. A write stores bits 10:4 and all other bits read zero. Addresses 4 to 7 read zero.
- R9: Address 3 reads raw AND mask. Each per-source output equals its masked bit.
- R10: `irq_any` is high exactly when any masked bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read word address |
| rd_data | output | 32 | Read data (combinational) |
| rx_count | input | 6 | Receive FIFO fill count, 0 to DEPTH |
| tx_count | input | 6 | Transmit FIFO fill count, 0 to DEPTH |
| ev_timeout | input | 1 | Receive timeout pulse |
| ev_frame | input | 1 | Framing error pulse |
| ev_parity | input | 1 | Parity error pulse |
| ev_break | input | 1 | Break error pulse |
| ev_overrun | input | 1 | Overrun error pulse |
| irq_rx | output | 1 | Masked receive-level interrupt |
| irq_tx | output | 1 | Masked transmit-level interrupt |
| irq_timeout | output | 1 | Masked timeout interrupt |
| irq_frame | output | 1 | Masked framing interrupt |
| irq_parity | output | 1 | Masked parity interrupt |
| irq_break | output | 1 | Masked break interrupt |
| irq_overrun | output | 1 | Masked overrun interrupt |
| irq_any | output | 1 | OR of all masked interrupts |

## Verification
Every register in the block can be read through the read port, so a wrong mask, level code or raw bit shows up at the ports in the same cycle a read selects it. It also shows up on the interrupt lines as soon as the corresponding mask bit is set.

A wrong threshold or a broken edge history shows up one clock after the count crosses the threshold: the raw bit either fails to set, or sets again after a clear while the condition still holds. The bench uses a cycle-by-cycle model to compare every output and a randomly chosen register on each clock, so any divergence is reported in the cycle it first becomes visible.

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int DEPTH = 32,
  parameter int AW    = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_addr,
  input  logic [31:0]                  wr_data,
  input  logic [AW-1:0]                rd_addr,
  output logic [31:0]                  rd_data,
  input  logic [$clog2(DEPTH+1)-1:0]   rx_count,
  input  logic [$clog2(DEPTH+1)-1:0]   tx_count,
  input  logic                         ev_timeout,
  input  logic                         ev_frame,
  input  logic                         ev_parity,
  input  logic                         ev_break,
  input  logic                         ev_overrun,
  output logic                         irq_rx,
  output logic                         irq_tx,
  output logic                         irq_timeout,
  output logic                         irq_frame,
  output logic                         irq_parity,
  output logic                         irq_break,
  output logic                         irq_overrun,
  output logic                         irq_any
);
  localparam int LW = $clog2(DEPTH+1);
  localparam int EIGHTH = DEPTH / 8;
  localparam logic [AW-1:0] A_LVL = AW'(0);
  localparam logic [AW-1:0] A_MSK = AW'(1);
  localparam logic [AW-1:0] A_RAW = AW'(2);
  localparam logic [AW-1:0] A_MIS = AW'(3);
  localparam logic [AW-1:0] A_CLR = AW'(4);

  function automatic logic [LW-1:0] thr_of(input logic [2:0] code);
    case (code)
      3'd0:    return LW'(EIGHTH);
      3'd1:    return LW'(2*EIGHTH);
      3'd2:    return LW'(4*EIGHTH);
      3'd3:    return LW'(6*EIGHTH);
      default: return LW'(7*EIGHTH);
    endcase
  endfunction

  logic [5:0]  lvl_q;
  logic [10:4] mask_q, raw_q, set_v, clr_v;
  logic        rx_hit, tx_hit, rx_hit_q, tx_hit_q;

  assign rx_hit = rx_count >= thr_of(lvl_q[5:3]);
  assign tx_hit = tx_count <= thr_of(lvl_q[2:0]);

  assign set_v = {ev_overrun, ev_break, ev_parity, ev_frame, ev_timeout,
                  tx_hit & ~tx_hit_q, rx_hit & ~rx_hit_q};
  assign clr_v = (wr_en && wr_addr == A_CLR) ? wr_data[10:4] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q    <= 6'b010_010;
      mask_q   <= '0;
      raw_q    <= '0;
      rx_hit_q <= 1'b0;
      tx_hit_q <= 1'b0;
    end else begin
      rx_hit_q <= rx_hit;
      tx_hit_q <= tx_hit;
      raw_q    <= (raw_q & ~clr_v) | set_v;
      if (wr_en && wr_addr == A_LVL) lvl_q  <= wr_data[5:0];
      if (wr_en && wr_addr == A_MSK) mask_q <= wr_data[10:4];
    end
  end

  logic [10:4] mis;
  assign mis = raw_q & mask_q;
  assign {irq_overrun, irq_break, irq_parity, irq_frame, irq_timeout, irq_tx, irq_rx} = mis;
  assign irq_any = |mis;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_LVL:   rd_data[5:0]  = lvl_q;
      A_MSK:   rd_data[10:4] = mask_q;
      A_RAW:   rd_data[10:4] = raw_q;
      A_MIS:   rd_data[10:4] = mis;
      default: rd_data = '0;
    endcase
  end

  // R2
  rx_edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_hit && !rx_hit_q) |=> raw_q[4]);
  // R6
  frame_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame |=> raw_q[7]);
  // R6
  frame_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q[7]) |-> $past(ev_frame));
  // R7
  parity_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CLR && wr_data[8] && !ev_parity) |=> !raw_q[8]);
  // R8
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_MSK) |=> mask_q == $past(wr_data[10:4]));
endmodule

// File: tb/tb_uart_irq_ctrl.sv
`timescale 1ns/1ps
module tb_uart_irq_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [5:0]  rx_count = '0, tx_count = '0;
  logic        ev_timeout = 0, ev_frame = 0, ev_parity = 0, ev_break = 0, ev_overrun = 0;
  logic        irq_rx, irq_tx, irq_timeout, irq_frame, irq_parity, irq_break, irq_overrun, irq_any;

  int tests = 0, fails = 0;

  uart_irq_ctrl dut (.*);

  always #2.5 clk = ~clk;

  logic [5:0]  m_lvl;
  logic [10:4] m_mask, m_raw;
  logic        m_prx, m_ptx;

  function automatic int thr(input logic [2:0] c);
    case (c)
      3'd0: return 4;
      3'd1: return 8;
      3'd2: return 16;
      3'd3: return 24;
      default: return 28;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic we, input logic [2:0] wa, input logic [31:0] wd,
                      input int rxl, input int txl, input logic [4:0] ev, input logic [2:0] ra);
    logic rxc, txc;
    logic [10:4] setv, clrv, mis;
    logic [31:0] exp_rd;
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    rx_count = 6'(rxl); tx_count = 6'(txl);
    {ev_overrun, ev_break, ev_parity, ev_frame, ev_timeout} = ev;
    rxc = rxl >= thr(m_lvl[5:3]);
    txc = txl <= thr(m_lvl[2:0]);
    setv = {ev, txc & ~m_ptx, rxc & ~m_prx};
    clrv = (we && wa == 3'd4) ? wd[10:4] : '0;
    @(posedge clk);
    m_raw = (m_raw & ~clrv) | setv;
    m_prx = rxc; m_ptx = txc;
    if (we && wa == 3'd0) m_lvl = wd[5:0];
    if (we && wa == 3'd1) m_mask = wd[10:4];
    #1;
    mis = m_raw & m_mask;
    check("R2 irq_rx", 32'(irq_rx), 32'(mis[4]));
    check("R3 irq_tx", 32'(irq_tx), 32'(mis[5]));
    check("R6 R9 irq_err", 32'({irq_overrun, irq_break, irq_parity, irq_frame, irq_timeout}), 32'(mis[10:6]));
    check("R10 irq_any", 32'(irq_any), 32'(|mis));
    exp_rd = '0;
    case (ra)
      3'd0: exp_rd[5:0] = m_lvl;
      3'd1: exp_rd[10:4] = m_mask;
      3'd2: exp_rd[10:4] = m_raw;
      3'd3: exp_rd[10:4] = mis;
      default: exp_rd = '0;
    endcase
    case (ra)
      3'd0: check("R4 level readback", rd_data, exp_rd);
      3'd1: check("R8 mask readback", rd_data, exp_rd);
      3'd2: check("R5 R7 raw readback", rd_data, exp_rd);
      3'd3: check("R9 masked readback", rd_data, exp_rd);
      default: check("R8 unused address", rd_data, exp_rd);
    endcase
    wr_en = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd_addr = 3'd0; #0.5;
    check("R1 level reset", rd_data, 32'h12);
    rd_addr = 3'd1; #0.5;
    check("R1 mask reset", rd_data, 32'h0);
    rd_addr = 3'd2; #0.5;
    check("R1 raw reset", rd_data, 32'h0);
    m_lvl = 6'h12; m_mask = '0; m_raw = '0; m_prx = 0; m_ptx = 0;
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 5'b0, 3'd2);
    step(1, 3'd1, 32'hFFFF_FFFF, 0, 0, 5'b0, 3'd1);
    // R2 R4 R5: receive threshold per code, reserved codes, no re-fire after clear
    for (int c = 0; c < 8; c++) begin
      step(1, 3'd0, 32'(c << 3) | 32'd4, 0, 0, 5'b0, 3'd0);
      step(1, 3'd4, 32'h7F0, 0, 0, 5'b0, 3'd2);
      step(0, 0, 0, thr(3'(c)) - 1, 0, 5'b0, 3'd2);
      step(0, 0, 0, thr(3'(c)), 0, 5'b0, 3'd2);
      step(0, 0, 0, thr(3'(c)), 0, 5'b0, 3'd3);
      step(1, 3'd4, 32'h10, thr(3'(c)), 0, 5'b0, 3'd2);
      step(0, 0, 0, 32, 0, 5'b0, 3'd2);
      step(0, 0, 0, 0, 0, 5'b0, 3'd2);
    end
    // R3 R4: transmit threshold per code
    for (int c = 0; c < 8; c++) begin
      step(1, 3'd0, 32'(c) | 32'h20, 0, 32, 5'b0, 3'd0);
      step(1, 3'd4, 32'h7F0, 0, 32, 5'b0, 3'd2);
      step(0, 0, 0, 0, thr(3'(c)) + 1, 5'b0, 3'd2);
      step(0, 0, 0, 0, thr(3'(c)), 5'b0, 3'd2);
      step(1, 3'd4, 32'h20, 0, thr(3'(c)), 5'b0, 3'd2);
      step(0, 0, 0, 0, 0, 5'b0, 3'd2);
    end
    // R6 R7: each event alone, then set versus clear in the same cycle
    for (int e = 0; e < 5; e++) begin
      step(0, 0, 0, 0, 32, 5'(1 << e), 3'd2);
      step(1, 3'd4, 32'h7F0, 0, 32, 5'b0, 3'd2);
    end
    step(1, 3'd4, 32'h7F0, 0, 32, 5'b11111, 3'd2);
    step(1, 3'd1, 32'h0000_0140, 0, 32, 5'b0, 3'd3);
    step(0, 0, 0, 0, 32, 5'b0, 3'd1);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] wa;
      logic [31:0] wd;
      int pick;
      pick = int'($urandom_range(0, 9));
      wa = (pick < 2) ? 3'd0 : (pick < 4) ? 3'd1 : 3'd4;
      wd = $urandom;
      step(pick < 6, wa, wd, int'($urandom_range(0, 32)), int'($urandom_range(0, 32)),
           5'($urandom) & 5'($urandom), 3'($urandom_range(0, 7)));
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule